// File: doc/BRIEF.md
# Page-Attributed Bus Slave Decoder

This block is the slave-side front end of a peripheral or memory on an on-chip bus. It covers an address window of `NUM_PAGES` pages of 4096 bytes each. Every page carries two 2-bit attributes, one for reads and one for writes. The attribute decides how an access to that page is handled:

- it is served from a small internal RAM;
- it is handed to the owning device over a forwarding port;
- it completes with a bus error;
- it completes harmlessly with no effect.

Because the two attributes are independent, a page can act as RAM, as ROM (memory reads, writes ignored or aborted), or as a register page. The owning logic can rewrite a page's attributes at any time through a control port. For example, a flash model can switch its reads from ROM to device handling while it is being programmed.

The block takes one request at a time and is controlled by a four-state machine:

- **ST_IDLE**: ready for a request.
- **ST_MEM**: the cycle in which the internal RAM read data returns.
- **ST_DEV**: a request is waiting on the device port.
- **ST_RESP**: the single cycle in which the response is driven.

The transitions are:

- **accept**: ST_IDLE to ST_MEM on a memory-mode read; ST_IDLE to ST_DEV on a device-mode access; ST_IDLE to ST_RESP on every other access.
- **mem_done**: ST_MEM to ST_RESP.
- **dev_done**: ST_DEV to ST_RESP when the device signals completion.
- **resp_sent**: ST_RESP to ST_IDLE.

Top module: `pas_slave`

## Requirements
- R1: After reset every page has the abort attribute for both reads and writes. `req_ready` is 1, `resp_valid` is 0 and `dev_valid` is 0.
- R2: A cycle with `cfg_we`=1 writes `cfg_rd_attr` and `cfg_wr_attr` into page `cfg_page`. The encoding is 00 memory, 01 device, 10 abort, 11 ignore. The read attribute governs reads and the write attribute governs writes, independently.
- R3: A memory-mode write stores the selected byte lanes in internal RAM; its response comes in the cycle after acceptance. A memory-mode read responds two cycles after acceptance with the stored bytes. Neither raises `dev_valid`.
- R4: A device-mode access raises `dev_valid` from the cycle after acceptance until the edge at which `dev_done` is sampled high. While `dev_valid` is high, `dev_write`, `dev_addr` (byte offset within the window), `dev_be` and `dev_wdata` are held stable. The response follows in the next cycle with error 0 and, for reads, `dev_rdata` restricted to the selected lanes.
- R5: An abort-mode access responds in the cycle after acceptance with `resp_err`=1 and zero data. It changes neither the RAM nor the device port.
- R6: An ignore-mode read returns zero with `resp_err`=0. An ignore-mode write completes with `resp_err`=0 and leaves the RAM unchanged. Together with memory-mode reads, this makes a page behave as ROM.
- R7: An access with an address at or beyond `NUM_PAGES`*4096, an address not aligned to its size, or a size above the data width returns `resp_err`=1, whatever the attribute.
- R8: `req_size` is log2 of the access width in bytes. The selected byte lanes start at address modulo `DATA_BYTES`. Read data outside the selected lanes is zero.
- R9: An attribute change takes effect from the next accepted request. A request already in flight completes under the attribute it was accepted with.
- R10: Only one request is outstanding at a time: `req_ready` is 1 only in ST_IDLE. `resp_valid` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high together with `req_valid` |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address relative to window base |
| req_size | input | SZ_W | log2 of access bytes |
| req_wdata | input | 8*DATA_BYTES | Write data, lane-aligned |
| resp_valid | output | 1 | Response pulse |
| resp_err | output | 1 | Bus error on this response |
| resp_rdata | output | 8*DATA_BYTES | Read data, unselected lanes zero |
| cfg_we | input | 1 | Attribute write strobe |
| cfg_page | input | PG_W | Page to update |
| cfg_rd_attr | input | 2 | New read attribute |
| cfg_wr_attr | input | 2 | New write attribute |
| dev_valid | output | 1 | Forwarded access pending |
| dev_write | output | 1 | Forwarded access is a write |
| dev_addr | output | WIN_W | Byte offset within the window |
| dev_be | output | DATA_BYTES | Selected byte lanes |
| dev_wdata | output | 8*DATA_BYTES | Forwarded write data |
| dev_done | input | 1 | Device completes the forwarded access |
| dev_rdata | input | 8*DATA_BYTES | Device read data |

## Verification
The stimulus covers every attribute value in both directions:

- A RAM page, filled with full-word and single-byte writes, shows that byte lanes merge and are masked correctly.
- A page set up as ROM shows that ignored writes leave the stored data untouched.
- A device page with sub-word reads separates forwarded data from internally served data.

The remaining cases cover each kind of failed access:

- Accesses outside the window, misaligned, or oversized each provoke an error on a page that would otherwise accept them.
- A device read whose page is switched to abort while the read is pending shows that the change applies only from the next request.

// File: rtl/pas_pkg.sv
package pas_pkg;
    typedef enum logic [1:0] {
        ATTR_MEM    = 2'b00,
        ATTR_DEV    = 2'b01,
        ATTR_ABORT  = 2'b10,
        ATTR_IGNORE = 2'b11
    } attr_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_MEM,
        ST_DEV,
        ST_RESP
    } state_t;

    localparam int PAGE_BYTES = 4096;
    localparam int PAGE_SHIFT = 12;
endpackage

// File: rtl/pas_decode.sv
module pas_decode #(
    parameter  int ADDR_W     = 32,
    parameter  int NUM_PAGES  = 2,
    parameter  int DATA_BYTES = 8,
    localparam int SZ_MAX     = $clog2(DATA_BYTES),
    localparam int SZ_W       = $clog2(SZ_MAX + 1) + 1,
    localparam int PG_W       = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1,
    localparam int WORD_W     = $clog2(NUM_PAGES * pas_pkg::PAGE_BYTES / DATA_BYTES)
) (
    input  logic [ADDR_W-1:0]     addr,
    input  logic [SZ_W-1:0]       size,
    output logic                  bad,
    output logic [PG_W-1:0]       page,
    output logic [WORD_W-1:0]     word,
    output logic [DATA_BYTES-1:0] be
);
    localparam int OFF_W = $clog2(DATA_BYTES);
    localparam logic [ADDR_W-1:0] WIN_END = ADDR_W'(NUM_PAGES * pas_pkg::PAGE_BYTES);

    int nbytes;
    int lane0;

    always_comb begin
        nbytes = 1 << int'(size);
        lane0  = int'(addr % ADDR_W'(DATA_BYTES));
        bad    = (int'(size) > SZ_MAX) || (addr >= WIN_END) ||
                 ((addr % ADDR_W'(nbytes)) != '0);
        page   = PG_W'(addr >> pas_pkg::PAGE_SHIFT);
        word   = WORD_W'(addr >> OFF_W);
        for (int i = 0; i < DATA_BYTES; i++) begin
            be[i] = (i >= lane0) && (i < lane0 + nbytes);
        end
    end
endmodule

// File: rtl/pas_attr_table.sv
module pas_attr_table #(
    parameter int NUM_PAGES = 2,
    parameter int PG_W      = 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic [PG_W-1:0]       cfg_page,
    input  pas_pkg::attr_t        cfg_rd,
    input  pas_pkg::attr_t        cfg_wr,
    input  logic [PG_W-1:0]       lk_page,
    output pas_pkg::attr_t        lk_rd,
    output pas_pkg::attr_t        lk_wr
);
    import pas_pkg::*;

    attr_t rd_q [NUM_PAGES];
    attr_t wr_q [NUM_PAGES];

    for (genvar g = 0; g < NUM_PAGES; g++) begin : g_page
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                rd_q[g] <= ATTR_ABORT;
                wr_q[g] <= ATTR_ABORT;
            end else if (cfg_we && cfg_page == PG_W'(g)) begin
                rd_q[g] <= cfg_rd;
                wr_q[g] <= cfg_wr;
            end
        end
    end

    always_comb begin
        lk_rd = ATTR_ABORT;
        lk_wr = ATTR_ABORT;
        for (int p = 0; p < NUM_PAGES; p++) begin
            if (lk_page == PG_W'(p)) begin
                lk_rd = rd_q[p];
                lk_wr = wr_q[p];
            end
        end
    end
endmodule

// File: rtl/pas_ram.sv
module pas_ram #(
    parameter int DATA_BYTES = 8,
    parameter int WORD_W     = 10
) (
    input  logic                    clk,
    input  logic                    we,
    input  logic                    re,
    input  logic [WORD_W-1:0]       addr,
    input  logic [DATA_BYTES-1:0]   be,
    input  logic [8*DATA_BYTES-1:0] wdata,
    output logic [8*DATA_BYTES-1:0] rdata
);
    localparam int WORDS = 1 << WORD_W;

    logic [8*DATA_BYTES-1:0] mem [WORDS];

    always_ff @(posedge clk) begin
        for (int b = 0; b < DATA_BYTES; b++) begin
            if (we && be[b]) begin
                mem[addr][8*b +: 8] <= wdata[8*b +: 8];
            end
        end
        if (re) begin
            rdata <= mem[addr];
        end
    end
endmodule

// File: rtl/pas_slave.sv
module pas_slave #(
    parameter  int ADDR_W     = 32,
    parameter  int NUM_PAGES  = 2,
    parameter  int DATA_BYTES = 8,
    localparam int DW         = 8 * DATA_BYTES,
    localparam int SZ_W       = $clog2($clog2(DATA_BYTES) + 1) + 1,
    localparam int PG_W       = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1,
    localparam int WIN_W      = $clog2(NUM_PAGES * 4096)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic                  req_write,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [SZ_W-1:0]       req_size,
    input  logic [DW-1:0]         req_wdata,
    output logic                  resp_valid,
    output logic                  resp_err,
    output logic [DW-1:0]         resp_rdata,
    input  logic                  cfg_we,
    input  logic [PG_W-1:0]       cfg_page,
    input  logic [1:0]            cfg_rd_attr,
    input  logic [1:0]            cfg_wr_attr,
    output logic                  dev_valid,
    output logic                  dev_write,
    output logic [WIN_W-1:0]      dev_addr,
    output logic [DATA_BYTES-1:0] dev_be,
    output logic [DW-1:0]         dev_wdata,
    input  logic                  dev_done,
    input  logic [DW-1:0]         dev_rdata
);
    import pas_pkg::*;

    localparam int WORD_W = $clog2(NUM_PAGES * PAGE_BYTES / DATA_BYTES);

    state_t state_q, state_d;

    logic                  dec_bad;
    logic [PG_W-1:0]       dec_page;
    logic [WORD_W-1:0]     dec_word;
    logic [DATA_BYTES-1:0] dec_be;
    attr_t                 lk_rd, lk_wr, cur_attr;
    logic                  accept;
    logic                  mem_we, mem_re;
    logic [DW-1:0]         mem_rdata;
    logic [DW-1:0]         lane_mask;

    logic                  err_q, wr_q;
    logic [DW-1:0]         data_q, wdata_q;
    logic [WIN_W-1:0]      addr_q;
    logic [DATA_BYTES-1:0] be_q;

    pas_decode #(.ADDR_W(ADDR_W), .NUM_PAGES(NUM_PAGES), .DATA_BYTES(DATA_BYTES)) u_dec (
        .addr (req_addr),
        .size (req_size),
        .bad  (dec_bad),
        .page (dec_page),
        .word (dec_word),
        .be   (dec_be)
    );

    pas_attr_table #(.NUM_PAGES(NUM_PAGES), .PG_W(PG_W)) u_tab (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_page (cfg_page),
        .cfg_rd   (attr_t'(cfg_rd_attr)),
        .cfg_wr   (attr_t'(cfg_wr_attr)),
        .lk_page  (dec_page),
        .lk_rd    (lk_rd),
        .lk_wr    (lk_wr)
    );

    assign accept   = req_valid && (state_q == ST_IDLE);
    assign cur_attr = req_write ? lk_wr : lk_rd;
    assign mem_we   = accept && !dec_bad && req_write  && (lk_wr == ATTR_MEM);
    assign mem_re   = accept && !dec_bad && !req_write && (lk_rd == ATTR_MEM);

    pas_ram #(.DATA_BYTES(DATA_BYTES), .WORD_W(WORD_W)) u_ram (
        .clk   (clk),
        .we    (mem_we),
        .re    (mem_re),
        .addr  (dec_word),
        .be    (dec_be),
        .wdata (req_wdata),
        .rdata (mem_rdata)
    );

    always_comb begin
        for (int b = 0; b < DATA_BYTES; b++) begin
            lane_mask[8*b +: 8] = {8{be_q[b]}};
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions: accept, mem_done, dev_done, resp_sent
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept) begin
                if (dec_bad)                                state_d = ST_RESP;
                else if (cur_attr == ATTR_DEV)              state_d = ST_DEV;
                else if (cur_attr == ATTR_MEM && !req_write) state_d = ST_MEM;
                else                                        state_d = ST_RESP;
            end
            ST_MEM:  state_d = ST_RESP;
            ST_DEV:  if (dev_done) state_d = ST_RESP;
            ST_RESP: state_d = ST_IDLE;
        endcase
    end

    // Request capture and response data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_q   <= 1'b0;
            wr_q    <= 1'b0;
            data_q  <= '0;
            wdata_q <= '0;
            addr_q  <= '0;
            be_q    <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (accept) begin
                    err_q   <= dec_bad || (cur_attr == ATTR_ABORT);
                    wr_q    <= req_write;
                    data_q  <= '0;
                    wdata_q <= req_wdata;
                    addr_q  <= WIN_W'(req_addr);
                    be_q    <= dec_be;
                end
                ST_MEM:  data_q <= mem_rdata & lane_mask;
                ST_DEV:  if (dev_done && !wr_q) data_q <= dev_rdata & lane_mask;
                ST_RESP: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        req_ready  = (state_q == ST_IDLE);
        resp_valid = (state_q == ST_RESP);
        dev_valid  = (state_q == ST_DEV);
        resp_err   = err_q;
        resp_rdata = data_q;
        dev_write  = wr_q;
        dev_addr   = addr_q;
        dev_be     = be_q;
        dev_wdata  = wdata_q;
    end

    // R10
    resp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);

    // R4
    dev_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dev_valid && !dev_done |=> dev_valid && $stable(dev_addr) && $stable(dev_be)
                                   && $stable(dev_write));

    // R5
    err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid && resp_err |-> resp_rdata == '0);

    // R7
    bad_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && dec_bad |=> resp_valid && resp_err);

    // R3
    mem_local_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && !dec_bad && cur_attr == ATTR_MEM |=> !dev_valid);
endmodule

// File: tb/pas_slave_tb.sv
module pas_slave_tb_top;
    localparam int DB = 8;
    localparam int DW = 64;
    localparam int WIN_BYTES = 8192;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0, req_write = 1'b0;
    logic [31:0]   req_addr = '0;
    logic [2:0]    req_size = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_ready, resp_valid, resp_err;
    logic [DW-1:0] resp_rdata;
    logic          cfg_we = 1'b0;
    logic [0:0]    cfg_page = '0;
    logic [1:0]    cfg_rd_attr = '0, cfg_wr_attr = '0;
    logic          dev_valid, dev_write;
    logic [12:0]   dev_addr;
    logic [DB-1:0] dev_be;
    logic [DW-1:0] dev_wdata;
    logic          dev_done = 1'b0;
    logic [DW-1:0] dev_rdata = '0;

    always #4 clk = ~clk;

    pas_slave dut_i (.*);

    int    tests = 0, fails = 0, cyc = 0, dcnt = 0;
    string cur_tag = "R1";

    // Reference model state: 0 idle, 1 mem, 2 dev, 3 resp
    int          m_st = 0;
    int          m_rd [2], m_wr [2];
    logic [7:0]  m_mem [int];
    logic        m_err, m_w;
    logic [DW-1:0] m_data, m_wd;
    logic [DB-1:0] m_be;
    int          m_addr;
    string       m_tag = "R1";

    function automatic logic [DW-1:0] lmask(logic [DB-1:0] be);
        logic [DW-1:0] m;
        for (int i = 0; i < DB; i++) m[8*i +: 8] = be[i] ? 8'hFF : 8'h00;
        return m;
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_st = 0;
            for (int p = 0; p < 2; p++) begin m_rd[p] = 2; m_wr[p] = 2; end
        end else begin
            case (m_st)
                0: if (req_valid) begin
                    int a, nb, at;
                    logic bad;
                    a = int'(req_addr);
                    nb = 1 << req_size;
                    bad = (req_size > 3) || (req_addr >= WIN_BYTES) || (a % nb != 0);
                    m_be = '0;
                    for (int i = 0; i < nb && !bad; i++) m_be[(a % DB) + i] = 1'b1;
                    at = bad ? 2 : (req_write ? m_wr[a / 4096] : m_rd[a / 4096]);
                    m_w = req_write; m_wd = req_wdata; m_addr = a;
                    m_err = (at == 2); m_data = '0; m_tag = cur_tag;
                    if (at == 0 && req_write) begin
                        for (int i = 0; i < DB; i++)
                            if (m_be[i]) m_mem[(a / DB) * DB + i] = req_wdata[8*i +: 8];
                        m_st = 3;
                    end else if (at == 0) begin
                        for (int i = 0; i < DB; i++)
                            if (m_be[i]) m_data[8*i +: 8] = m_mem[(a / DB) * DB + i];
                        m_st = 1;
                    end else if (at == 1) m_st = 2;
                    else m_st = 3;
                end
                1: m_st = 3;
                2: if (dev_done) begin
                    if (!m_w) m_data = dev_rdata & lmask(m_be);
                    m_st = 3;
                end
                default: m_st = 0;
            endcase
            if (cfg_we) begin
                m_rd[cfg_page] = int'(cfg_rd_attr);
                m_wr[cfg_page] = int'(cfg_wr_attr);
            end
        end
    end

    // Per-cycle comparison
    always @(negedge clk) begin
        if (rst_n) begin
            tests++;
            if (req_ready !== (m_st == 0) || resp_valid !== (m_st == 3) || dev_valid !== (m_st == 2)) begin
                fails++;
                $display("FAIL R10 handshake: ready=%0b valid=%0b dev=%0b expected state %0d",
                         req_ready, resp_valid, dev_valid, m_st);
            end
            if (m_st == 3) begin
                tests++;
                if (resp_err !== m_err || resp_rdata !== m_data) begin
                    fails++;
                    $display("FAIL %s response: err=%0b data=%h expected err=%0b data=%h",
                             m_tag, resp_err, resp_rdata, m_err, m_data);
                end
            end
            if (m_st == 2) begin
                tests++;
                if (dev_write !== m_w || dev_addr !== 13'(m_addr) || dev_be !== m_be ||
                    (m_w && dev_wdata !== m_wd)) begin
                    fails++;
                    $display("FAIL R4 device port: w=%0b addr=%h be=%h expected w=%0b addr=%h be=%h",
                             dev_write, dev_addr, dev_be, m_w, 13'(m_addr), m_be);
                end
            end
        end
    end

    // Device model: completes after two cycles of dev_valid
    always @(negedge clk) begin
        if (dev_valid && !dev_done) begin
            dcnt++;
            if (dcnt >= 2) begin
                dev_done = 1'b1;
                dev_rdata = 64'hD1D2_D3D4_0000_0000 | 64'(dev_addr);
                dcnt = 0;
            end
        end else dev_done = 1'b0;
    end

    task automatic do_cfg(input int pg, input int ra, input int wa);
        @(negedge clk);
        cfg_we = 1'b1; cfg_page = 1'(pg); cfg_rd_attr = 2'(ra); cfg_wr_attr = 2'(wa);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic do_req(input string tag, input logic w, input int a, input int sz,
                          input logic [DW-1:0] wd, input bit cfg_mid = 0,
                          input int pg = 0, input int ra = 0, input int wa = 0);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        cur_tag = tag;
        req_valid = 1'b1; req_write = w; req_addr = 32'(a); req_size = 3'(sz); req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        if (cfg_mid) begin
            cfg_we = 1'b1; cfg_page = 1'(pg); cfg_rd_attr = 2'(ra); cfg_wr_attr = 2'(wa);
            @(negedge clk);
            cfg_we = 1'b0;
        end
        while (!resp_valid) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        tests++;
        if (req_ready !== 1'b1 || resp_valid !== 1'b0 || dev_valid !== 1'b0) begin
            fails++;
            $display("FAIL R1 reset outputs: ready=%0b valid=%0b dev=%0b expected 1 0 0",
                     req_ready, resp_valid, dev_valid);
        end
        do_req("R1", 1'b0, 'h0, 3, '0);
        do_req("R1", 1'b1, 'h1008, 2, 64'h55);
        // R2 R3 RAM page
        do_cfg(0, 0, 0);
        do_req("R3", 1'b1, 'h10, 3, 64'h8877_6655_4433_2211);
        do_req("R3", 1'b0, 'h10, 3, '0);
        do_req("R8", 1'b1, 'h13, 0, 64'h0000_0000_AB00_0000);
        do_req("R8", 1'b0, 'h14, 2, '0);
        do_req("R8", 1'b0, 'h12, 1, '0);
        // R6 ROM page
        do_cfg(1, 0, 0);
        do_req("R3", 1'b1, 'h1008, 3, 64'hCAFE_F00D_1234_5678);
        do_cfg(1, 0, 3);
        do_req("R6", 1'b1, 'h1008, 3, 64'hFFFF_FFFF_FFFF_FFFF);
        do_req("R6", 1'b0, 'h1008, 3, '0);
        do_cfg(0, 3, 0);
        do_req("R6", 1'b0, 'h10, 3, '0);
        // R4 device page
        do_cfg(1, 1, 1);
        do_req("R4", 1'b1, 'h1020, 2, 64'h0000_0000_1357_9BDF);
        do_req("R4", 1'b0, 'h1024, 2, '0);
        do_req("R8", 1'b0, 'h1027, 0, '0);
        // R5 abort writes on a RAM-read page
        do_cfg(0, 0, 2);
        do_req("R5", 1'b1, 'h10, 3, 64'h0);
        do_req("R5", 1'b0, 'h10, 3, '0);
        // R7 bad accesses on a RAM page
        do_cfg(0, 0, 0);
        do_req("R7", 1'b0, 'h2000, 3, '0);
        do_req("R7", 1'b0, 'h11, 1, '0);
        do_req("R7", 1'b0, 'h10, 4, '0);
        do_req("R7", 1'b1, 'h14, 3, 64'h1);
        do_req("R7", 1'b0, 'h10, 3, '0);
        // R9 in-flight device read while the page turns to abort
        do_req("R9", 1'b0, 'h1040, 3, '0, 1'b1, 1, 2, 2);
        do_req("R9", 1'b0, 'h1040, 3, '0);
        do_req("R2", 1'b0, 'h1FF8, 3, '0);
        repeat (3) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        wait (cyc > 100000);
        fails++;
        $display("FAIL watchdog: cycle %0d expected completion", cyc);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule